// File: doc/BRIEF.md
# Bit-Scan and Population-Count Unit

This block returns one of three bit statistics of a data word in a single registered cycle: the number of set bits, the position of the lowest set bit, or the position of the highest set bit. An opcode picks the operation. The block takes the operand, the opcode and the current value of the destination register, and it accepts one new operation every clock. Its latency is the same for every operand value. No iterative search is used.

All three operations run through one adder-tree population counter. For a scan, the operand is first re-encoded so that counting its ones gives the wanted index. For a forward scan, the encoding keeps only the zeros below the lowest one. For a reverse scan, it smears the highest one downward. A scan of an all-zero operand raises the zero flag and passes the previous destination value through unchanged, so the destination register keeps its contents.

Top module: `bitcount_unit`

## Requirements
- R1: `in_op` is encoded as follows: 2'b00 = population count, 2'b01 = forward scan, 2'b10 = reverse scan. The value 2'b11 is handled exactly like population count.
- R2: Population count returns the number of ones in `in_operand`, and `out_zero` is 1 exactly when the operand is zero. The result is written even when it is zero.
- R3: Forward scan of a nonzero operand returns the bit index of its least significant one.
- R4: Reverse scan of a nonzero operand returns the bit index of its most significant one.
- R5: A forward or reverse scan of a zero operand sets `out_zero` to 1 and returns `in_prev_dest` unchanged as the result.
- R6: A forward or reverse scan of a nonzero operand clears `out_zero` to 0.
- R7: An operation presented with `in_valid` high at a rising edge appears on `out_result`/`out_zero` with `out_valid` high after exactly that one edge, for every operand value. Back-to-back operations are accepted every cycle.
- R8: In a cycle with `in_valid` low, the next edge drives `out_valid` low and leaves `out_result` and `out_zero` at their previous values.
- R9: While `rst_n` is low, `out_valid`, `out_result` and `out_zero` are all 0. Reset is applied asynchronously and released on the clock.
- R10: The result is $clog2(DATA_W)+1 bits wide, so a population count of an all-ones operand returns DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Operation select (R1 encoding) |
| in_operand | input | DATA_W | Source word |
| in_prev_dest | input | $clog2(DATA_W)+1 | Current destination value, returned on a zero-operand scan |
| out_valid | output | 1 | Result valid |
| out_result | output | $clog2(DATA_W)+1 | Count or bit index |
| out_zero | output | 1 | Source operand was zero |

## Verification
The hardest cases to reach are the scan corner cases at the two ends of the word. These are a lone one in bit 0 or in the top bit, where the encoders produce all-zero or all-one words, and a zero operand, where the result comes from `in_prev_dest` rather than from the counter. Random operands almost never hit these cases. The stimulus therefore walks a single one across every bit position under each opcode, and applies all-ones and all-zeros words with changing `in_prev_dest` values. It then mixes in random operands, random idle cycles and the spare opcode. A behavioural model checks the outputs on every clock.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    BSC_OP_POPCNT = 2'b00,
    BSC_OP_SCANF  = 2'b01,
    BSC_OP_SCANR  = 2'b10,
    BSC_OP_SPARE  = 2'b11
  } bsc_op_e;

endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/bsc_encoder.sv
module bsc_encoder
  import bsc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] operand_i,
  input  bsc_op_e           op_i,
  output logic [DATA_W-1:0] word_o
);

  localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] below_low;
  logic [DATA_W-1:0] smeared;

  // Ones strictly below the lowest set bit: their count is that bit's index.
  always_comb begin
    below_low = (operand_i - ONE_W) & ~operand_i;
  end

  // Fill every position at or below the highest set bit.
  always_comb begin
    smeared = operand_i;
    for (int sh = 1; sh < DATA_W; sh = sh * 2) begin
      smeared = smeared | (smeared >> sh);
    end
  end

  always_comb begin
    unique case (op_i)
      BSC_OP_SCANF: word_o = below_low;
      BSC_OP_SCANR: word_o = smeared;
      default:      word_o = operand_i;
    endcase
  end

endmodule

// File: rtl/bsc_popcount_tree.sv
module bsc_popcount_tree #(
  parameter int DATA_W = 64,
  parameter int RES_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [RES_W-1:0]  count_o
);

  localparam int LEVELS = $clog2(DATA_W);

  for (genvar lv = 0; lv <= LEVELS; lv++) begin : lvl_g
    localparam int NODES = DATA_W >> lv;
    logic [RES_W-1:0] node [NODES];
    if (lv == 0) begin : leaf_g
      for (genvar n = 0; n < NODES; n++) begin : bit_g
        assign node[n] = {{(RES_W-1){1'b0}}, word_i[n]};
      end
    end else begin : add_g
      for (genvar n = 0; n < NODES; n++) begin : pair_g
        assign node[n] = lvl_g[lv-1].node[2*n] + lvl_g[lv-1].node[2*n+1];
      end
    end
  end

  assign count_o = lvl_g[LEVELS].node[0];

endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
  import bsc_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int RES_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [RES_W-1:0]  in_prev_dest,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_result,
  output logic              out_zero
);

  localparam logic [RES_W-1:0] ONE_R = {{(RES_W-1){1'b0}}, 1'b1};

  logic              core_rst_n;
  bsc_op_e           op_sel;
  logic [DATA_W-1:0] enc_word;
  logic [RES_W-1:0]  tree_count;
  logic              src_is_zero;
  logic              cap_en;
  logic [RES_W-1:0]  result_d;
  logic              zero_d;
  logic              valid_q;
  logic [RES_W-1:0]  result_q;
  logic              zero_q;

  bsc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign op_sel = bsc_op_e'(in_op);

  bsc_encoder #(.DATA_W(DATA_W)) u_encoder (
    .operand_i (in_operand),
    .op_i      (op_sel),
    .word_o    (enc_word)
  );

  bsc_popcount_tree #(.DATA_W(DATA_W), .RES_W(RES_W)) u_tree (
    .word_i  (enc_word),
    .count_o (tree_count)
  );

  // Next-state logic
  always_comb begin
    src_is_zero = ~|in_operand;
    zero_d      = src_is_zero;
    unique case (op_sel)
      BSC_OP_SCANF: result_d = src_is_zero ? in_prev_dest : tree_count;
      BSC_OP_SCANR: result_d = src_is_zero ? in_prev_dest : (tree_count - ONE_R);
      default:      result_d = tree_count;
    endcase
  end

  assign cap_en = in_valid;

  // Registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      zero_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (cap_en) begin
        result_q <= result_d;
        zero_q   <= zero_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = result_q;
  assign out_zero   = zero_q;

endmodule

// File: rtl/bitcount_unit_checker.sv
module bitcount_unit_checker #(
  parameter int DATA_W = 64,
  parameter int RES_W  = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_operand,
  input logic [RES_W-1:0]  in_prev_dest,
  input logic              out_valid,
  input logic [RES_W-1:0]  out_result,
  input logic              out_zero
);

  localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_zero)));

  assert_scan_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == 2'b01 || in_op == 2'b10) && in_operand == '0)
      |=> (out_zero && out_result == $past(in_prev_dest)));

  assert_scan_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_operand != '0) |=> !out_zero);

  assert_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[0] == in_op[1])
      |=> (int'(out_result) == $countones($past(in_operand))));

  assert_fwd_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && in_operand != '0)
      |=> ((($past(in_operand) >> out_result) & ONE_W) == ONE_W
           && ($past(in_operand) << (DATA_W - int'(out_result))) == '0));

  assert_rev_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && in_operand != '0)
      |=> (($past(in_operand) >> out_result) == ONE_W));

  always_comb begin
    if (!rst_n) begin
      assert_reset_R9: assert (out_valid == 1'b0 || $isunknown(out_valid));
    end
  end

endmodule

bind bitcount_unit bitcount_unit_checker #(.DATA_W(DATA_W), .RES_W(RES_W)) u_checker (
  .clk          (clk),
  .rst_n        (core_rst_n),
  .in_valid     (in_valid),
  .in_op        (in_op),
  .in_operand   (in_operand),
  .in_prev_dest (in_prev_dest),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_zero     (out_zero)
);

// File: tb/bitcount_unit_tb_top.sv
module bitcount_unit_tb_top;

  localparam int DATA_W = 64;
  localparam int RES_W  = $clog2(DATA_W) + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [1:0]        in_op;
  logic [DATA_W-1:0] in_operand;
  logic [RES_W-1:0]  in_prev_dest;
  logic              out_valid;
  logic [RES_W-1:0]  out_result;
  logic              out_zero;

  always #10 clk = ~clk;

  bitcount_unit #(.DATA_W(DATA_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_operand   (in_operand),
    .in_prev_dest (in_prev_dest),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_zero     (out_zero)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 1'b0;

  logic             exp_valid;
  logic [RES_W-1:0] exp_res;
  logic             exp_zero;
  string            exp_tag;

  function automatic int ref_pop(logic [DATA_W-1:0] v);
    int c = 0;
    for (int i = 0; i < DATA_W; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic int ref_low(logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int ref_high(logic [DATA_W-1:0] v);
    for (int i = DATA_W - 1; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  // Behavioural reference model, one result per accepted operation.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_res   <= '0;
      exp_zero  <= 1'b0;
      exp_tag   <= "R9";
    end else begin
      exp_valid <= in_valid;
      if (!in_valid) begin
        exp_tag <= "R8";
      end else begin
        exp_zero <= (in_operand == '0);
        case (in_op)
          2'b01: begin
            if (in_operand == '0) begin exp_res <= in_prev_dest; exp_tag <= "R5"; end
            else begin exp_res <= RES_W'(ref_low(in_operand)); exp_tag <= "R3"; end
          end
          2'b10: begin
            if (in_operand == '0) begin exp_res <= in_prev_dest; exp_tag <= "R5"; end
            else begin exp_res <= RES_W'(ref_high(in_operand)); exp_tag <= "R4"; end
          end
          default: begin
            exp_res <= RES_W'(ref_pop(in_operand));
            if (in_op == 2'b11)           exp_tag <= "R1";
            else if (&in_operand)         exp_tag <= "R10";
            else                          exp_tag <= "R2";
          end
        endcase
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (out_valid !== exp_valid) begin
        fails++;
        $display("FAIL R7 out_valid actual=%b expected=%b", out_valid, exp_valid);
      end else if (out_zero !== exp_zero && exp_zero == 1'b0 &&
                   (exp_tag == "R3" || exp_tag == "R4")) begin
        fails++;
        $display("FAIL R6 out_zero actual=%b expected=%b", out_zero, exp_zero);
      end else if (out_result !== exp_res || out_zero !== exp_zero) begin
        fails++;
        $display("FAIL %s result/zero actual=%0d/%b expected=%0d/%b",
                 exp_tag, out_result, out_zero, exp_res, exp_zero);
      end
    end
  end

  task automatic drive(input logic v, input logic [1:0] op,
                       input logic [DATA_W-1:0] opnd, input logic [RES_W-1:0] prev);
    @(negedge clk);
    in_valid     = v;
    in_op        = op;
    in_operand   = opnd;
    in_prev_dest = prev;
  endtask

  function automatic logic [DATA_W-1:0] rnd_word();
    logic [DATA_W-1:0] w = '0;
    for (int i = 0; i < DATA_W; i += 32) w = (w << 32) | DATA_W'($urandom);
    return w;
  endfunction

  initial begin
    rst_n        = 1'b0;
    in_valid     = 1'b0;
    in_op        = 2'b00;
    in_operand   = '0;
    in_prev_dest = '0;
    repeat (3) @(negedge clk);            // R9 reset state compared here
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: zero operand scans with changing previous destination
    drive(1'b1, 2'b01, '0, RES_W'(37));
    drive(1'b1, 2'b10, '0, RES_W'(5));
    drive(1'b1, 2'b01, '0, '1);
    drive(1'b1, 2'b00, '0, RES_W'(9));    // R2 zero popcount written
    // R10: all ones
    drive(1'b1, 2'b00, '1, '0);
    drive(1'b1, 2'b01, '1, '0);
    drive(1'b1, 2'b10, '1, '0);
    drive(1'b1, 2'b11, '1, '0);           // R1 spare opcode
    // R3/R4: single one walked across the word, back to back (R7)
    for (int b = 0; b < DATA_W; b++) begin
      for (int op = 0; op < 4; op++) begin
        drive(1'b1, 2'(op), ONE << b, RES_W'(b));
      end
    end
    // Pairs at the ends
    drive(1'b1, 2'b01, {1'b1, {(DATA_W-2){1'b0}}, 1'b1}, '0);
    drive(1'b1, 2'b10, {1'b1, {(DATA_W-2){1'b0}}, 1'b1}, '0);
    drive(1'b1, 2'b00, {(DATA_W/2){2'b10}}, '0);
    // R8: idle cycles with changing inputs
    drive(1'b0, 2'b00, '1, '1);
    drive(1'b0, 2'b10, '0, RES_W'(3));
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [DATA_W-1:0] w = rnd_word();
      if ($urandom_range(0, 7) == 0) w = '0;
      if ($urandom_range(0, 7) == 0) w = w & (w >> $urandom_range(1, 40));
      drive($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), w, RES_W'($urandom));
    end
    drive(1'b0, 2'b00, '0, '0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule